// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the housekeeping side of an asynchronous DRAM with separate strobes for the row and for each byte lane's column. After reset it keeps every access away for a pause measured in clock cycles. It then runs a burst of wake-up RAS cycles and raises an initialisation flag. From then on it produces one refresh cycle per refresh interval. By default each refresh is a CAS-before-RAS cycle. In that mode the memory's own row counter picks the row, the address pins are left alone and the data pins never leave high impedance. A build-time option switches to RAS-only refresh. In that mode the block drives a row address from its own counter while both CAS lanes stay high.

The strobe pins are shared with an access controller. The sequencer raises `ref_req`. It moves the strobes only while `ref_gnt` is high, and it drops the request once the precharge of its last cycle has ended. A refresh that is due but not yet granted is kept as pending, and several pending refreshes are served one grant each. If a refresh falls due while the pending store is already full, the memory may have lost data. The block then raises a sticky overdue flag, withdraws the initialisation flag, and turns its next grant into a complete wake-up burst.

Top module: `dram_refresh_seq`

## Requirements
- R1: For the first PAUSE_CYC clock cycles after reset is released, `ref_req` stays low and all strobes stay high. The first request appears in cycle PAUSE_CYC+1. While in reset, every strobe is high and `init_done` and `overdue` are low.
- R2: The first grant after the pause carries WAKE_CNT complete RAS cycles. `init_done` rises only after the precharge of the last of these cycles.
- R3: Once initialised, with prompt grants, the block makes one refresh cycle per REF_INTERVAL clock cycles.
- R4: In CAS-before-RAS mode, both CAS lanes are low for CSR_CYC cycles before RAS falls. They stay low for the first CHR_CYC cycles of the RAS-low phase. RAS is low for RAS_CYC cycles. Before the next RAS fall there are at least RP_CYC+CSR_CYC cycles with RAS high.
- R5: In CAS-before-RAS mode, `row_addr_en` never goes high, and the two CAS lanes fall and rise in the same cycle.
- R6: The strobes move only while `ref_gnt` is high. Once raised, `ref_req` stays high until it is granted. The block raises no new request until it has seen `ref_gnt` low.
- R7: A refresh that falls due without being granted is added to a pending count, which holds at most MAX_PEND. When grants resume, each pending refresh yields one refresh cycle, with a separate grant for each.
- R8: If a refresh falls due while the pending count already equals MAX_PEND, `overdue` rises and stays high until reset, and `init_done` falls in the same cycle.
- R9: After an overflow, the next grant carries WAKE_CNT RAS cycles, and `init_done` then returns high.
- R10: In RAS-only mode, both CAS lanes stay high and `row_addr_en` is high when RAS falls. The row presented with the first cycle after reset is 0, and the row then advances by one, modulo 2^ROW_W, after each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Access controller hands the strobe pins to this block |
| ref_req | output | 1 | Request for the strobe pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Column strobe for the low byte lane, active low |
| cas_hi_n | output | 1 | Column strobe for the high byte lane, active low |
| row_addr_en | output | 1 | Row address on `row_addr` is to be driven onto the address pins |
| row_addr | output | ROW_W | Row for RAS-only refresh |
| init_done | output | 1 | Wake-up sequence complete; the memory may be accessed |
| overdue | output | 1 | Sticky flag: the pending store overflowed |

## Verification
The bench builds the main instance with a 40-cycle pause, a 100-cycle interval, strobe widths of two to four cycles and room for three pending refreshes. Each of the wake-up burst, a backlog of exactly three pending refreshes, an overflow and the wake-up that follows then fits within a few hundred cycles, and the stretch with randomly delayed grants can still be run against an exact timing check of every strobe. A second instance runs in RAS-only mode with a 4-bit row counter and a 30-cycle interval, so the row address wraps several times during the run.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC    = 20000,
  parameter int REF_INTERVAL = 1560,
  parameter int WAKE_CNT     = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 5,
  parameter int RP_CYC       = 4,
  parameter int MAX_PEND     = 7,
  parameter int ROW_W        = 10,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_lo_n,
  output logic             cas_hi_n,
  output logic             row_addr_en,
  output logic [ROW_W-1:0] row_addr,
  output logic             init_done,
  output logic             overdue
);
  localparam int T1   = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
  localparam int T2   = (T1 > CSR_CYC) ? T1 : CSR_CYC;
  localparam int TMAX = (T2 > RP_CYC) ? T2 : RP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(REF_INTERVAL + 1);
  localparam int PW   = $clog2(MAX_PEND + 1);
  localparam int BW   = $clog2(WAKE_CNT + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_REQ, S_SETUP, S_RAS, S_PRE} st_t;

  st_t         st;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] burst;
  logic [IW-1:0] icnt;
  logic [PW-1:0] pend;
  logic        waking, rewake, init_q, overdue_q;

  wire tick     = (st != S_PAUSE) && (icnt == IW'(REF_INTERVAL - 1));
  wire take     = (st == S_REQ) && ref_gnt;
  wire pre_end  = (st == S_PRE) && (tcnt == TW'(RP_CYC - 1));
  wire last_end = pre_end && (burst == BW'(1));
  wire cas_act  = !RAS_ONLY && ((st == S_SETUP) || ((st == S_RAS) && (tcnt < TW'(CHR_CYC))));

  assign ref_req     = (st == S_REQ) || (st == S_SETUP) || (st == S_RAS) || (st == S_PRE);
  assign ras_n       = (st != S_RAS);
  assign cas_lo_n    = !cas_act;
  assign cas_hi_n    = !cas_act;
  assign row_addr_en = RAS_ONLY && ((st == S_SETUP) || (st == S_RAS));
  assign init_done   = init_q;
  assign overdue     = overdue_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PAUSE;
      tcnt   <= '0;
      burst  <= '0;
      waking <= 1'b0;
    end else begin
      case (st)
        S_PAUSE:
          if (tcnt == TW'(PAUSE_CYC - 1)) begin
            st   <= S_IDLE;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        S_IDLE:
          if (!ref_gnt && (rewake || pend != '0)) st <= S_REQ;
        S_REQ:
          if (ref_gnt) begin
            st     <= S_SETUP;
            tcnt   <= '0;
            burst  <= rewake ? BW'(WAKE_CNT) : BW'(1);
            waking <= rewake;
          end
        S_SETUP:
          if (tcnt == TW'(CSR_CYC - 1)) begin
            st   <= S_RAS;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        S_RAS:
          if (tcnt == TW'(RAS_CYC - 1)) begin
            st   <= S_PRE;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        S_PRE:
          if (pre_end) begin
            tcnt  <= '0;
            burst <= burst - 1'b1;
            if (last_end) begin
              st     <= S_IDLE;
              waking <= 1'b0;
            end else st <= S_SETUP;
          end else tcnt <= tcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt      <= '0;
      pend      <= '0;
      rewake    <= 1'b1;
      init_q    <= 1'b0;
      overdue_q <= 1'b0;
    end else begin
      if (st != S_PAUSE) icnt <= tick ? '0 : icnt + 1'b1;
      if (last_end && waking && !rewake) init_q <= 1'b1;
      if (take && rewake) begin
        pend   <= tick ? PW'(1) : '0;
        rewake <= 1'b0;
      end else if (tick && !take) begin
        if (pend == PW'(MAX_PEND)) begin
          overdue_q <= 1'b1;
          rewake    <= 1'b1;
          init_q    <= 1'b0;
        end else pend <= pend + 1'b1;
      end else if (take && !tick) pend <= pend - 1'b1;
    end
  end

  generate
    if (RAS_ONLY) begin : g_row
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else if (pre_end) row_q <= row_q + 1'b1;
      end
      assign row_addr = row_q;
    end else begin : g_norow
      assign row_addr = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int PAUSE_CYC = 20000,
  parameter int ROW_W     = 10,
  parameter bit RAS_ONLY  = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             ras_n,
  input logic             cas_lo_n,
  input logic             cas_hi_n,
  input logic             row_addr_en,
  input logic [ROW_W-1:0] row_addr,
  input logic             init_done,
  input logic             overdue
);
  localparam int CW = $clog2(PAUSE_CYC + 1);
  logic [CW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (pcnt != CW'(PAUSE_CYC)) pcnt <= pcnt + 1'b1;
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt < CW'(PAUSE_CYC)) |-> (!ref_req && ras_n && cas_lo_n && cas_hi_n));

  assert_pins_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_gnt |-> (ras_n && cas_lo_n && cas_hi_n));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!RAS_ONLY && $fell(ras_n)) |-> (!cas_lo_n && !cas_hi_n && $past(!cas_lo_n)));

  assert_no_addr_cbr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!RAS_ONLY && $fell(ras_n)) |-> (!row_addr_en && !$past(row_addr_en)));

  assert_overdue_drops_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdue) |-> !init_done);

  assert_overdue_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |=> overdue);

  assert_ras_only_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY && $fell(ras_n)) |-> (row_addr_en && cas_lo_n && cas_hi_n));

  assert_row_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (row_addr == $past(row_addr) + 1'b1));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC(PAUSE_CYC), .ROW_W(ROW_W), .RAS_ONLY(RAS_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ras_n(ras_n),
  .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .row_addr_en(row_addr_en),
  .row_addr(row_addr), .init_done(init_done), .overdue(overdue)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int CLK_P = 10;
  localparam int PAUSE = 40;
  localparam int INTV  = 100;
  localparam int WAKE  = 8;
  localparam int CSR   = 2;
  localparam int CHR   = 2;
  localparam int RASW  = 4;
  localparam int RP    = 2;
  localparam int MAXP  = 3;

  logic clk = 0, rst_n = 0;
  logic gnt0 = 0, gnt1 = 0;
  logic req0, ras0, cl0, ch0, ae0, init0, od0;
  logic req1, ras1, cl1, ch1, ae1, init1, od1;
  logic [9:0] row0;
  logic [3:0] row1;

  always #(CLK_P/2) clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .REF_INTERVAL(INTV), .WAKE_CNT(WAKE), .CSR_CYC(CSR),
    .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP), .MAX_PEND(MAXP), .ROW_W(10), .RAS_ONLY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt0), .ref_req(req0), .ras_n(ras0), .cas_lo_n(cl0),
    .cas_hi_n(ch0), .row_addr_en(ae0), .row_addr(row0), .init_done(init0), .overdue(od0));

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .REF_INTERVAL(30), .WAKE_CNT(WAKE), .CSR_CYC(CSR),
    .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP), .MAX_PEND(MAXP), .ROW_W(4), .RAS_ONLY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt1), .ref_req(req1), .ras_n(ras1), .cas_lo_n(cl1),
    .cas_hi_n(ch1), .row_addr_en(ae1), .row_addr(row1), .init_done(init1), .overdue(od1));

  int n_tests = 0, n_fail = 0;
  bit allow0 = 1;
  int max_dly = 0, wait0 = 0;
  bit preq0 = 0, pras0 = 1, pras1 = 1;
  int casrun = 0, rasrun = 0, hirun = 1000, casin = 0, pulses = 0, pulses1 = 0;
  int exp_row = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic bit in_range(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic monitor();
    if (pras0 && !ras0) begin
      chk(!cl0 && !ch0, "R4 cas low at ras fall", {cl0, ch0}, 0);
      chk(casrun == CSR, "R4 cas setup cycles", casrun, CSR);
      chk(hirun >= RP + CSR, "R4 ras high cycles", hirun, RP + CSR);
      chk(gnt0, "R6 strobe moved with grant", gnt0, 1);
      chk(!ae0, "R5 no address in cbr", ae0, 0);
      pulses++;
      rasrun = 0; casin = 0;
    end
    if (!pras0 && ras0) begin
      chk(rasrun == RASW, "R4 ras low cycles", rasrun, RASW);
      chk(casin == CHR, "R4 cas hold cycles", casin, CHR);
      hirun = 0;
    end
    chk(cl0 == ch0, "R5 lanes together", {cl0, ch0}, {cl0, cl0});
    if (!ras0) begin rasrun++; if (!cl0) casin++; end else hirun++;
    casrun = !cl0 ? casrun + 1 : 0;
    pras0 = ras0;
    if (pras1 && !ras1) begin
      chk(cl1 && ch1, "R10 cas high", {cl1, ch1}, 3);
      chk(ae1, "R10 address enabled", ae1, 1);
      chk(row1 == exp_row[3:0], "R10 row value", row1, exp_row);
      exp_row = (exp_row + 1) % 16;
      pulses1++;
    end
    pras1 = ras1;
  endtask

  task automatic drive();
    if (!rst_n) begin gnt0 = 0; gnt1 = 0; end
    else begin
      if (req0 && !preq0) wait0 = (max_dly == 0) ? 0 : int'($urandom_range(max_dly, 0));
      if (!req0) gnt0 = 0;
      else if (!gnt0 && allow0) begin
        if (wait0 == 0) gnt0 = 1; else wait0--;
      end
      gnt1 = req1;
    end
    preq0 = req0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) monitor();
      drive();
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_req0();
    for (int i = 0; i < 400 && !(req0 && !preq0); i++) @(negedge clk);
  endtask

  initial begin
    int cyc, p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!req0 && ras0 && cl0 && ch0, "R1 reset pins", {req0, ras0, cl0, ch0}, 7);
    chk(!init0 && !od0, "R1 reset flags", {init0, od0}, 0);
    rst_n = 1;
    cyc = 0;
    for (int i = 0; i < 200 && !req0; i++) begin
      @(negedge clk);
      cyc++;
      if (!ras0 || !cl0) chk(0, "R1 strobe during pause", cyc, 0);
    end
    chk(cyc == PAUSE + 1, "R1 first request cycle", cyc, PAUSE + 1);

    for (int i = 0; i < 400 && !init0; i++) @(negedge clk);
    chk(init0 == 1, "R2 init_done raised", init0, 1);
    chk(pulses == WAKE, "R2 wake pulses", pulses, WAKE);

    wait_req0();
    p0 = pulses;
    repeat (10 * INTV) @(negedge clk);
    chk(in_range(pulses - p0, 9, 11), "R3 refreshes in 10 intervals", pulses - p0, 10);

    max_dly = 5;
    p0 = pulses;
    repeat (15 * INTV) @(negedge clk);
    chk(in_range(pulses - p0, 14, 16), "R3 refreshes with random grant delay", pulses - p0, 15);
    chk(init0 && !od0, "R6 no overdue under short delays", {init0, od0}, 2);
    max_dly = 0;

    wait_req0();
    allow0 = 0;
    repeat (250) @(negedge clk);
    chk(!od0 && init0, "R7 backlog below limit", {od0, init0}, 1);
    p0 = pulses;
    allow0 = 1;
    repeat (45) @(negedge clk);
    chk(pulses - p0 == MAXP, "R7 pending refreshes served", pulses - p0, MAXP);

    wait_req0();
    allow0 = 0;
    repeat (5 * INTV) @(negedge clk);
    chk(od0 == 1, "R8 overdue set", od0, 1);
    chk(init0 == 0, "R8 init_done cleared", init0, 0);
    p0 = pulses;
    allow0 = 1;
    for (int i = 0; i < 400 && !init0; i++) @(negedge clk);
    chk(init0 == 1, "R9 init_done restored", init0, 1);
    chk(pulses - p0 == WAKE, "R9 wake pulses after overflow", pulses - p0, WAKE);
    chk(od0 == 1, "R8 overdue sticky", od0, 1);

    chk(pulses1 >= 20, "R10 row counter wrapped", pulses1, 20);
    chk(!ae0, "R5 cbr address enable idle", ae0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule